// File: doc/BRIEF.md
# Row-Column One-Hot Byte Memory

This block is a small byte-wide store laid out as a square grid of storage elements. A flat binary address is cut into two fields. The high field picks a row and the low field picks a column. Each field is decoded into its own one-hot select bus. An element responds only where its row line and its column line are both high. Every element therefore carries the same two-input gate and no address comparator of its own.

All data moves over one shared bidirectional byte bus. A chip enable starts an access, and a write control sets its direction. On a write, the addressed element takes the bus value at the rising clock edge. On a read, the addressed element places its stored byte on the bus combinationally within the same cycle. At every other time the block releases the bus, so an outside agent can drive it without contention.

A build parameter selects a second decoding variant. In that variant each element gets the full address and enables itself on an exact match with its own fixed location. Seen from the ports, both variants must behave the same.

Top module: `rcg_grid_mem`

## Requirements
- R1: With default parameters there are 64 byte locations in 8 rows by 8 columns. Address bits [5:3] select the row and bits [2:0] select the column, and each address maps to its own location.
- R2: When chipEn=1 and wrEn=1 at a rising clock edge, the byte on dataBus is stored in the addressed location.
- R3: When chipEn=1 and wrEn=0, the block drives the addressed location's stored byte onto dataBus in the same cycle, with no clock edge needed.
- R4: When chipEn=0, or when wrEn=1, the block does not drive dataBus. An external driver's value then appears on the bus unaltered.
- R5: During an access, exactly one row select line and exactly one column select line are high. With chipEn=0 none are high, and at most one element ever drives the bus.
- R6: A write changes only the addressed location. All other locations keep their contents.
- R7: A synchronous active-high reset clears every location to zero. Reset takes priority over a write in the same cycle.
- R8: With chipEn=0, wrEn=1 and a clock edge, no location changes.
- R9: The full-address-compare decoding variant (MODE=DEC_COMPARE) gives the same results at the ports as the one-hot variant for every stimulus above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all locations |
| chipEn | input | 1 | Access enable; when low the block is idle and the bus is released |
| wrEn | input | 1 | Direction: 1 = write from bus, 0 = read onto bus |
| addr | input | 6 | Flat address: row field in [5:3], column field in [2:0] |
| dataBus | inout | 8 | Shared bidirectional data bus |

## Verification
Every location is written with the byte (37*a+11) mod 256, which differs for each of the 64 addresses, and then read back. A swapped row/column field, a stuck select line or a dead element therefore shows up as a wrong byte at a known address. A single overwrite with the inverted pattern, followed by a full sweep, separates correct gating from writes that leak into a neighbouring row or column. Idle cycles with the bench driving 0x00 over non-zero contents expose any driver the block fails to release. Disabled write attempts and a reset that coincides with a write test the no-effect and priority cases. Both decoding variants receive identical stimulus and are checked against the same computed values.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

  typedef enum logic {
    DEC_ONEHOT  = 1'b0,
    DEC_COMPARE = 1'b1
  } decodeMode_e;

  typedef struct packed {
    logic active;
    logic doWrite;
    logic doRead;
  } memStrobe_t;

endpackage

// File: rtl/rcg_ctrl.sv
module rcg_ctrl
  import rcg_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chipEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output memStrobe_t        strobe,
  output logic [ROWS-1:0]   rowSel,
  output logic [COLS-1:0]   colSel
);

  logic [ROW_BITS-1:0] rowField;
  logic [COL_BITS-1:0] colField;

  assign rowField = addr[ADDR_W-1 -: ROW_BITS];
  assign colField = addr[COL_BITS-1:0];

  assign strobe.active  = chipEn;
  assign strobe.doWrite = chipEn & wrEn;
  assign strobe.doRead  = chipEn & ~wrEn;

  for (genvar r = 0; r < ROWS; r++) begin : g_rowDec
    assign rowSel[r] = chipEn && (rowField == ROW_BITS'(r));
  end

  for (genvar c = 0; c < COLS; c++) begin : g_colDec
    assign colSel[c] = chipEn && (colField == COL_BITS'(c));
  end

  // R5: one row line and one column line per access, none when idle
  p_row_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    chipEn |-> $onehot(rowSel));
  p_col_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    chipEn |-> $onehot(colSel));
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !chipEn |-> (rowSel == '0 && colSel == '0));
  // R1: the high line of each bus is the one named by its address field
  p_row_field_r1: assert property (@(posedge clk) disable iff (rst)
    chipEn |-> rowSel[rowField]);
  p_col_field_r1: assert property (@(posedge clk) disable iff (rst)
    chipEn |-> colSel[colField]);

endmodule

// File: rtl/rcg_cell.sv
module rcg_cell #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              doWrite,
  input  logic              doRead,
  input  logic [DATA_W-1:0] wrData,
  output logic              drvEn,
  output logic [DATA_W-1:0] drvData
);

  logic [DATA_W-1:0] stored;
  logic              capture;

  assign capture = hit & doWrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      stored <= '0;
    end else if (capture) begin
      stored <= wrData;
    end
  end

  // switchable non-inverting buffer: passes the byte only while enabled
  assign drvEn   = hit & doRead;
  assign drvData = drvEn ? stored : '0;

  // R2: a selected write lands in this element
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    capture |=> (stored == $past(wrData)));
  // R6/R8: without a selected write the element keeps its byte
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(stored));

endmodule

// File: rtl/rcg_datapath.sv
module rcg_datapath
  import rcg_pkg::*;
#(
  parameter int          ROW_BITS = 3,
  parameter int          COL_BITS = 3,
  parameter int          DATA_W   = 8,
  parameter decodeMode_e MODE     = DEC_ONEHOT,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS,
  localparam int ELEMS = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst,
  input  memStrobe_t        strobe,
  input  logic [ROWS-1:0]   rowSel,
  input  logic [COLS-1:0]   colSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] busIn,
  output logic              busDrive,
  output logic [DATA_W-1:0] busOut
);

  logic [ELEMS-1:0]  hitVec;
  logic [ELEMS-1:0]  drvEnVec;
  logic [DATA_W-1:0] drvDataArr [ELEMS];

  if (MODE == DEC_COMPARE) begin : g_cmpMode
    logic unusedSelBits;
    assign unusedSelBits = ^{rowSel, colSel};
  end else begin : g_ohMode
    logic unusedAddrBits;
    assign unusedAddrBits = ^addr;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int ELEM = r * COLS + c;

      if (MODE == DEC_COMPARE) begin : g_match
        assign hitVec[ELEM] = strobe.active && (addr == ADDR_W'(ELEM));
      end else begin : g_cross
        assign hitVec[ELEM] = rowSel[r] & colSel[c];
      end

      rcg_cell #(.DATA_W(DATA_W)) i_cell (
        .clk     (clk),
        .rst     (rst),
        .hit     (hitVec[ELEM]),
        .doWrite (strobe.doWrite),
        .doRead  (strobe.doRead),
        .wrData  (busIn),
        .drvEn   (drvEnVec[ELEM]),
        .drvData (drvDataArr[ELEM])
      );
    end
  end

  always_comb begin
    busOut = '0;
    for (int i = 0; i < ELEMS; i++) begin
      busOut = busOut | drvDataArr[i];
    end
  end

  assign busDrive = |drvEnVec;

  // R5: never more than one element on the bus
  p_single_driver_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drvEnVec));
  // R3: a read always puts exactly one element on the bus
  p_read_drives_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.doRead |-> $onehot(drvEnVec));
  // R4: the bus is released outside reads
  p_idle_release_r4: assert property (@(posedge clk) disable iff (rst)
    !strobe.doRead |-> !busDrive);
  // R1: an access enables exactly one element
  p_one_element_r1: assert property (@(posedge clk) disable iff (rst)
    strobe.active |-> $onehot(hitVec));

endmodule

// File: rtl/rcg_grid_mem.sv
module rcg_grid_mem
  import rcg_pkg::*;
#(
  parameter int          ROW_BITS = 3,
  parameter int          COL_BITS = 3,
  parameter int          DATA_W   = 8,
  parameter decodeMode_e MODE     = DEC_ONEHOT,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chipEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dataBus
);

  memStrobe_t        strobe;
  logic [ROWS-1:0]   rowSel;
  logic [COLS-1:0]   colSel;
  logic              busDrive;
  logic [DATA_W-1:0] busOut;

  rcg_ctrl #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS)
  ) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .chipEn (chipEn),
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe),
    .rowSel (rowSel),
    .colSel (colSel)
  );

  rcg_datapath #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .DATA_W   (DATA_W),
    .MODE     (MODE)
  ) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .rowSel   (rowSel),
    .colSel   (colSel),
    .addr     (addr),
    .busIn    (dataBus),
    .busDrive (busDrive),
    .busOut   (busOut)
  );

  assign dataBus = busDrive ? busOut : {DATA_W{1'bz}};

endmodule

// File: tb/test_rcg_grid_mem.sv
`timescale 1ns/1ps
module test_rcg_grid_mem;
  import rcg_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chipEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] tbDrv = '0;
  logic       tbDrvEn = 1'b0;
  wire  [7:0] busA;
  wire  [7:0] busB;
  int         nChecks = 0;
  int         nErrors = 0;

  assign busA = tbDrvEn ? tbDrv : 8'bz;
  assign busB = tbDrvEn ? tbDrv : 8'bz;

  always #5 clk = ~clk;

  rcg_grid_mem #(.MODE(DEC_ONEHOT)) i_rcg_grid_mem (
    .clk(clk), .rst(rst), .chipEn(chipEn), .wrEn(wrEn), .addr(addr), .dataBus(busA));

  rcg_grid_mem #(.MODE(DEC_COMPARE)) i_rcg_grid_mem_cmp (
    .clk(clk), .rst(rst), .chipEn(chipEn), .wrEn(wrEn), .addr(addr), .dataBus(busB));

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) % 256);
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeByte(input int a, input logic [7:0] d, input logic ce);
    @(negedge clk);
    chipEn = ce; wrEn = 1'b1; addr = 6'(a); tbDrv = d; tbDrvEn = 1'b1;
    @(negedge clk);
    chipEn = 1'b0; wrEn = 1'b0; tbDrvEn = 1'b0;
  endtask

  task automatic readCheck(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    chipEn = 1'b1; wrEn = 1'b0; tbDrvEn = 1'b0; addr = 6'(a);
    #1;
    check(busA, exp, {tag, " one-hot"});
    check(busB, exp, {tag, " compare R9"});
    chipEn = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R7: reset state is all zero
    for (int a = 0; a < 64; a++) readCheck(a, 8'h00, "R7 reset clear");

    // R1/R2: fill every location with a distinct byte
    for (int a = 0; a < 64; a++) writeByte(a, pat(a), 1'b1);
    // R1/R2/R3: read them all back
    for (int a = 0; a < 64; a++) readCheck(a, pat(a), "R1/R2/R3 readback");

    // R4 and R8: idle write attempt with the bench holding 0x00 on the bus
    for (int a = 0; a < 64; a += 9) begin
      @(negedge clk);
      chipEn = 1'b0; wrEn = 1'b1; addr = 6'(a); tbDrv = 8'h00; tbDrvEn = 1'b1;
      #1;
      check(busA, 8'h00, "R4 bus released one-hot");
      check(busB, 8'h00, "R4 bus released compare R9");
      @(negedge clk);
      wrEn = 1'b0; tbDrvEn = 1'b0;
      readCheck(a, pat(a), "R8 disabled write ignored");
    end

    // R4: during a write the block leaves the bench value intact
    @(negedge clk);
    chipEn = 1'b1; wrEn = 1'b1; addr = 6'd20; tbDrv = pat(20); tbDrvEn = 1'b1;
    #1;
    check(busA, pat(20), "R4 no drive during write one-hot");
    check(busB, pat(20), "R4 no drive during write compare R9");
    @(negedge clk);
    chipEn = 1'b0; wrEn = 1'b0; tbDrvEn = 1'b0;

    // R6: overwrite one location, sweep all
    writeByte(9, ~pat(9), 1'b1);
    for (int a = 0; a < 64; a++)
      readCheck(a, (a == 9) ? ~pat(a) : pat(a), "R6 isolated write");

    // R7: reset coinciding with a write wins
    @(negedge clk);
    rst = 1'b1; chipEn = 1'b1; wrEn = 1'b1; addr = 6'd3; tbDrv = 8'h77; tbDrvEn = 1'b1;
    @(negedge clk);
    rst = 1'b0; chipEn = 1'b0; wrEn = 1'b0; tbDrvEn = 1'b0;
    for (int a = 0; a < 64; a++) readCheck(a, 8'h00, "R7 reset over write");

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule